// File: doc/BRIEF.md
# Frame Transmit Sequencer

This block runs one wireless MAC frame transmission from start to finish, using per-frame settings that software writes before each run. Software starts a run by writing the start bit high and then low. The block reacts only to the rising edge of that bit. At that edge it captures the settings.

Before sending, the sequencer picks one of several paths:
- It can hold for a fixed interval that an outside timer measures.
- It can send at once when the medium has been idle long enough.
- It can load a fresh backoff count into the outside backoff counter.
- It can wait on a backoff that is already counting.

It then gives the PHY a single-cycle start pulse, together with a packet buffer index and an antenna mask. After the PHY reports that the frame is out, the sequencer can open a response window. A new reception or a timer expiry closes that window.

A done pulse and a two-bit result code report the outcome. The interval timers, the backoff counter, carrier sense and the PHY all sit outside the block. The block reaches them only through level inputs, done inputs and strobes.

States:
- `ST_IDLE` waits for a start edge.
- `ST_PRE_RX` waits for the post-receive timer.
- `ST_PRE_TX` waits for the first post-transmit timer.
- `ST_BO_LOAD` loads the backoff counter.
- `ST_BO_WAIT` waits for the backoff to finish.
- `ST_TX_GO` issues the PHY start.
- `ST_TX_WAIT` waits for the end of transmission.
- `ST_RESP_WAIT` is the response window.

Transitions:
- `ST_IDLE` to `ST_PRE_RX` when pre-wait rx is set.
- `ST_IDLE` to `ST_PRE_TX` when only pre-wait tx is set.
- `ST_IDLE` to `ST_BO_WAIT` when a backoff is running.
- `ST_IDLE` to `ST_TX_GO` when the medium is idle for DIFS.
- `ST_IDLE` to `ST_BO_LOAD` in every other case.
- `ST_PRE_RX` or `ST_PRE_TX` to `ST_TX_GO` on the matching timer done.
- `ST_BO_LOAD` to `ST_BO_WAIT` unconditionally.
- `ST_BO_WAIT` to `ST_TX_GO` on backoff done.
- `ST_TX_GO` to `ST_TX_WAIT` unconditionally.
- `ST_TX_WAIT` to `ST_RESP_WAIT` when post-wait is set, or to `ST_IDLE` when it is not.
- `ST_RESP_WAIT` to `ST_IDLE` on a reception or on timer expiry.

Top module: `txseq_ctrl`

## Requirements
- R1: While `rst_n` is low, from any state, `busy`, `done`, `phy_start` and `bo_load` are 0 and `result` is 00. After release, no earlier run continues.
- R2: A run starts only on a 0-to-1 change of `sw_go`. When `sw_go` stays high after a run has ended, no second run starts.
- R3: A rising edge of `sw_go` while `busy` is 1 is ignored. It does not restart the run, load a backoff or start the PHY.
- R4: When `cfg_wait_rx1` is 1 at start, `phy_start` stays 0 until `rx1_done` is seen. `phy_start` then rises in the cycle after that. `bo_load` is never raised on this path.
- R5: When only `cfg_wait_tx1` is 1, the same holds with `tx1_done`. When both pre-wait bits are 1, the post-receive wait wins and `tx1_done` has no effect.
- R6: With no pre-wait, `medium_idle_difs` at 1 and `bo_active` at 0, `phy_start` rises in the cycle after the start edge and `bo_load` stays 0.
- R7: With no pre-wait, medium not idle and no backoff running, `bo_load` pulses for one cycle in the cycle after the start edge. During that pulse `bo_slots` equals the captured slot count. `phy_start` follows one cycle after `bo_done` is seen.
- R8: With no pre-wait and `bo_active` at 1, the block defers without loading (`bo_load` stays 0) and transmits one cycle after `bo_done`.
- R9: `phy_start` is a single-cycle pulse. `phy_buf_idx` and `phy_ant_mask` carry the values captured at the start edge and ignore later changes of the settings.
- R10: With `cfg_wait_tx2` at 0, the cycle after `phy_tx_done` brings `done` = 1 with `result` = 00.
- R11: With `cfg_wait_tx2` at 1, the block stays busy after `phy_tx_done`. A `phy_rx_start` then gives `done` with `result` = 01.
- R12: In the response window, `tx2_done` alone gives `done` with `result` = 10. When `tx2_done` and `phy_rx_start` arrive in the same cycle, the result is 01.
- R13: `busy` is 1 exactly while a run is in progress. `done` is a single-cycle pulse, raised in the first idle cycle, and `result` holds until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_go | input | 1 | Software start bit; its rising edge starts a run |
| cfg_buf_idx | input | BUF_W | Packet buffer index for the frame |
| cfg_ant_mask | input | ANT_W | Antenna selection mask |
| cfg_bo_slots | input | SLOT_W | Backoff slot count to load |
| cfg_wait_rx1 | input | 1 | Pre-wait on the post-receive timer |
| cfg_wait_tx1 | input | 1 | Pre-wait on the first post-transmit timer |
| cfg_wait_tx2 | input | 1 | Open the response window after sending |
| rx1_done | input | 1 | Post-receive timer expired |
| tx1_done | input | 1 | First post-transmit timer expired |
| tx2_done | input | 1 | Second post-transmit (timeout) timer expired |
| bo_done | input | 1 | Backoff counter reached zero |
| bo_active | input | 1 | A backoff is currently counting |
| medium_idle_difs | input | 1 | Medium idle for at least DIFS |
| phy_tx_done | input | 1 | PHY finished sending |
| phy_rx_start | input | 1 | PHY detected a new reception |
| bo_load | output | 1 | Load strobe to the backoff counter |
| bo_slots | output | SLOT_W | Slot count presented with `bo_load` |
| phy_start | output | 1 | Start-transmit pulse to the PHY |
| phy_buf_idx | output | BUF_W | Buffer index presented with `phy_start` |
| phy_ant_mask | output | ANT_W | Antenna mask presented with `phy_start` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 00 sent, 01 response received, 10 timeout |

## Verification
The bench builds the block with `BUF_W` = 3, `ANT_W` = 2 and `SLOT_W` = 4. These narrow fields let all-ones values (buffer 7, mask 3, slot count 15) reach the top bit of every captured field, so a dropped or shifted bit shows up at the PHY or backoff outputs. Each route out of idle is driven with its own input mix, including both pre-wait bits set together and a second start edge during a backoff. The simultaneous arrival of `tx2_done` and `phy_rx_start` is also covered.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_RX,
        ST_PRE_TX,
        ST_BO_LOAD,
        ST_BO_WAIT,
        ST_TX_GO,
        ST_TX_WAIT,
        ST_RESP_WAIT
    } txseq_state_e;

    typedef enum logic [1:0] {
        RES_SENT = 2'b00,
        RES_RESP = 2'b01,
        RES_TMO  = 2'b10
    } txseq_res_e;

    typedef struct packed {
        logic wait_rx1;
        logic wait_tx1;
        logic wait_tx2;
    } txseq_mode_t;

endpackage

// File: rtl/txseq_edge.sv
module txseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/txseq_cfg.sv
module txseq_cfg
    import txseq_pkg::*;
#(
    parameter int BUF_W  = 5,
    parameter int ANT_W  = 4,
    parameter int SLOT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BUF_W-1:0]  buf_in,
    input  logic [ANT_W-1:0]  ant_in,
    input  logic [SLOT_W-1:0] slots_in,
    input  txseq_mode_t       mode_in,
    output logic [BUF_W-1:0]  buf_q,
    output logic [ANT_W-1:0]  ant_q,
    output logic [SLOT_W-1:0] slots_q,
    output txseq_mode_t       mode_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            ant_q   <= '0;
            slots_q <= '0;
            mode_q  <= '0;
        end else if (capture) begin
            buf_q   <= buf_in;
            ant_q   <= ant_in;
            slots_q <= slots_in;
            mode_q  <= mode_in;
        end
    end
endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
    import txseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_edge,
    input  txseq_mode_t mode_now,
    input  txseq_mode_t mode_q,
    input  logic        rx1_done,
    input  logic        tx1_done,
    input  logic        tx2_done,
    input  logic        bo_done,
    input  logic        bo_active,
    input  logic        idle_difs,
    input  logic        phy_tx_done,
    input  logic        phy_rx_start,
    output logic        accept,
    output logic        bo_load,
    output logic        phy_start,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result
);
    txseq_state_e state, nxt;
    logic         fin;
    txseq_res_e   fin_code;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and completion code
    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_code = RES_SENT;
        unique case (state)
            ST_IDLE: begin
                if (go_edge) begin
                    if (mode_now.wait_rx1)      nxt = ST_PRE_RX;
                    else if (mode_now.wait_tx1) nxt = ST_PRE_TX;
                    else if (bo_active)         nxt = ST_BO_WAIT;
                    else if (idle_difs)         nxt = ST_TX_GO;
                    else                        nxt = ST_BO_LOAD;
                end
            end
            ST_PRE_RX:  if (rx1_done) nxt = ST_TX_GO;
            ST_PRE_TX:  if (tx1_done) nxt = ST_TX_GO;
            ST_BO_LOAD: nxt = ST_BO_WAIT;
            ST_BO_WAIT: if (bo_done) nxt = ST_TX_GO;
            ST_TX_GO:   nxt = ST_TX_WAIT;
            ST_TX_WAIT: begin
                if (phy_tx_done) begin
                    if (mode_q.wait_tx2) begin
                        nxt = ST_RESP_WAIT;
                    end else begin
                        nxt      = ST_IDLE;
                        fin      = 1'b1;
                        fin_code = RES_SENT;
                    end
                end
            end
            ST_RESP_WAIT: begin
                if (phy_rx_start) begin
                    nxt      = ST_IDLE;
                    fin      = 1'b1;
                    fin_code = RES_RESP;
                end else if (tx2_done) begin
                    nxt      = ST_IDLE;
                    fin      = 1'b1;
                    fin_code = RES_TMO;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = go_edge && (state == ST_IDLE);
        bo_load   = (state == ST_BO_LOAD);
        phy_start = (state == ST_TX_GO);
        busy      = (state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= RES_SENT;
        end else begin
            done <= fin;
            if (fin) result <= fin_code;
        end
    end
endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
    import txseq_pkg::*;
#(
    parameter int BUF_W  = 5,
    parameter int ANT_W  = 4,
    parameter int SLOT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_go,
    input  logic [BUF_W-1:0]  cfg_buf_idx,
    input  logic [ANT_W-1:0]  cfg_ant_mask,
    input  logic [SLOT_W-1:0] cfg_bo_slots,
    input  logic              cfg_wait_rx1,
    input  logic              cfg_wait_tx1,
    input  logic              cfg_wait_tx2,
    input  logic              rx1_done,
    input  logic              tx1_done,
    input  logic              tx2_done,
    input  logic              bo_done,
    input  logic              bo_active,
    input  logic              medium_idle_difs,
    input  logic              phy_tx_done,
    input  logic              phy_rx_start,
    output logic              bo_load,
    output logic [SLOT_W-1:0] bo_slots,
    output logic              phy_start,
    output logic [BUF_W-1:0]  phy_buf_idx,
    output logic [ANT_W-1:0]  phy_ant_mask,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    logic        go_edge;
    logic        accept;
    txseq_mode_t mode_now;
    txseq_mode_t mode_q;

    assign mode_now = '{wait_rx1: cfg_wait_rx1,
                        wait_tx1: cfg_wait_tx1,
                        wait_tx2: cfg_wait_tx2};

    txseq_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sw_go),
        .rise (go_edge)
    );

    txseq_cfg #(
        .BUF_W (BUF_W),
        .ANT_W (ANT_W),
        .SLOT_W(SLOT_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .buf_in  (cfg_buf_idx),
        .ant_in  (cfg_ant_mask),
        .slots_in(cfg_bo_slots),
        .mode_in (mode_now),
        .buf_q   (phy_buf_idx),
        .ant_q   (phy_ant_mask),
        .slots_q (bo_slots),
        .mode_q  (mode_q)
    );

    txseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_edge     (go_edge),
        .mode_now    (mode_now),
        .mode_q      (mode_q),
        .rx1_done    (rx1_done),
        .tx1_done    (tx1_done),
        .tx2_done    (tx2_done),
        .bo_done     (bo_done),
        .bo_active   (bo_active),
        .idle_difs   (medium_idle_difs),
        .phy_tx_done (phy_tx_done),
        .phy_rx_start(phy_rx_start),
        .accept      (accept),
        .bo_load     (bo_load),
        .phy_start   (phy_start),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );
endmodule

// File: rtl/txseq_ctrl_chk.sv
module txseq_ctrl_chk #(
    parameter int BUF_W = 5,
    parameter int ANT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bo_load,
    input logic             phy_start,
    input logic             busy,
    input logic             done,
    input logic [1:0]       result,
    input logic [BUF_W-1:0] phy_buf_idx,
    input logic [ANT_W-1:0] phy_ant_mask
);
    // R1: outputs quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!busy && !done && !phy_start && !bo_load);
        end
    end

    // R9: PHY start lasts one cycle
    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        phy_start |=> !phy_start);

    // R9: fields do not move during a run
    a_r9_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy_buf_idx) && $stable(phy_ant_mask)));

    // R7: backoff load is one cycle and the run continues after it
    a_r7_load_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        bo_load |=> (busy && !bo_load && !phy_start));

    // R13: done is one cycle and only when idle
    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: result code is one of the three defined values
    a_r10_result_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));

    // R13: a run ends only through done
    a_r13_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind txseq_ctrl txseq_ctrl_chk #(
    .BUF_W(BUF_W),
    .ANT_W(ANT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bo_load     (bo_load),
    .phy_start   (phy_start),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .phy_buf_idx (phy_buf_idx),
    .phy_ant_mask(phy_ant_mask)
);

// File: tb/txseq_ctrl_bench.sv
`timescale 1ns/1ps
module txseq_ctrl_bench;
    localparam int BW = 3;
    localparam int AW = 2;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_go = 1'b0;
    logic [BW-1:0] cfg_buf_idx = '0;
    logic [AW-1:0] cfg_ant_mask = '0;
    logic [SW-1:0] cfg_bo_slots = '0;
    logic          cfg_wait_rx1 = 1'b0, cfg_wait_tx1 = 1'b0, cfg_wait_tx2 = 1'b0;
    logic          rx1_done = 1'b0, tx1_done = 1'b0, tx2_done = 1'b0;
    logic          bo_done = 1'b0, bo_active = 1'b0, medium_idle_difs = 1'b0;
    logic          phy_tx_done = 1'b0, phy_rx_start = 1'b0;
    logic          bo_load, phy_start, busy, done;
    logic [SW-1:0] bo_slots;
    logic [BW-1:0] phy_buf_idx;
    logic [AW-1:0] phy_ant_mask;
    logic [1:0]    result;

    int checks = 0;
    int errors = 0;
    int q_phy[$];
    int q_bo[$];
    int q_res[$];

    always #5 clk = ~clk;

    txseq_ctrl #(.BUF_W(BW), .ANT_W(AW), .SLOT_W(SW)) u_txseq_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_go(sw_go),
        .cfg_buf_idx(cfg_buf_idx), .cfg_ant_mask(cfg_ant_mask), .cfg_bo_slots(cfg_bo_slots),
        .cfg_wait_rx1(cfg_wait_rx1), .cfg_wait_tx1(cfg_wait_tx1), .cfg_wait_tx2(cfg_wait_tx2),
        .rx1_done(rx1_done), .tx1_done(tx1_done), .tx2_done(tx2_done),
        .bo_done(bo_done), .bo_active(bo_active), .medium_idle_difs(medium_idle_difs),
        .phy_tx_done(phy_tx_done), .phy_rx_start(phy_rx_start),
        .bo_load(bo_load), .bo_slots(bo_slots), .phy_start(phy_start),
        .phy_buf_idx(phy_buf_idx), .phy_ant_mask(phy_ant_mask),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_cfg(int b, int a, int s, bit wrx, bit wtx, bit wtx2);
        cfg_buf_idx  = BW'(b);
        cfg_ant_mask = AW'(a);
        cfg_bo_slots = SW'(s);
        cfg_wait_rx1 = wrx;
        cfg_wait_tx1 = wtx;
        cfg_wait_tx2 = wtx2;
    endtask

    task automatic expect_run(int b, int a, int res);
        q_phy.push_back((b << AW) | a);
        q_res.push_back(res);
    endtask

    // monitor: compares outputs with the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (phy_start) begin
                if (q_phy.size() == 0) chk("R9 unexpected phy_start", 1, 0);
                else chk("R9 phy fields", int'({phy_buf_idx, phy_ant_mask}), q_phy.pop_front());
            end
            if (bo_load) begin
                if (q_bo.size() == 0) chk("R8 unexpected bo_load", 1, 0);
                else chk("R7 bo_slots", int'(bo_slots), q_bo.pop_front());
            end
            if (done) begin
                if (q_res.size() == 0) chk("R13 unexpected done", 1, 0);
                else chk("R10 result code", int'(result), q_res.pop_front());
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 result in reset", result, 0);
        chk("R1 phy_start in reset", phy_start, 0);
        chk("R1 bo_load in reset", bo_load, 0);
        rst_n = 1'b1;
        tick();

        // R6 direct send, R9 field capture, R10 plain result
        set_cfg(5, 3, 0, 0, 0, 0);
        medium_idle_difs = 1'b1;
        expect_run(5, 3, 0);
        sw_go = 1'b1; tick();
        chk("R6 phy_start after edge", phy_start, 1);
        chk("R6 no bo_load", bo_load, 0);
        chk("R13 busy in run", busy, 1);
        sw_go = 1'b0; cfg_buf_idx = 3'd2; tick();
        chk("R9 phy_start single", phy_start, 0);
        chk("R9 buf held", phy_buf_idx, 5);
        phy_tx_done = 1'b1; tick();
        phy_tx_done = 1'b0;
        chk("R10 done", done, 1);
        chk("R10 result", result, 0);
        chk("R13 busy after run", busy, 0);
        tick();
        chk("R13 done single", done, 0);

        // R2 level held high gives one run
        set_cfg(7, 1, 0, 0, 0, 0);
        expect_run(7, 1, 0);
        sw_go = 1'b1; tick(); tick();
        phy_tx_done = 1'b1; tick();
        phy_tx_done = 1'b0;
        tick(); tick(); tick();
        chk("R2 no rerun busy", busy, 0);
        chk("R2 no rerun phy_start", phy_start, 0);
        sw_go = 1'b0; tick();

        // R4 and R5 priority: both pre-waits set
        set_cfg(6, 2, 9, 1, 1, 0);
        expect_run(6, 2, 0);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk("R4 busy in pre-wait", busy, 1);
        chk("R4 no phy_start yet", phy_start, 0);
        tx1_done = 1'b1; tick(); tx1_done = 1'b0;
        chk("R5 tx1_done ignored", phy_start, 0);
        tick();
        chk("R4 still waiting", phy_start, 0);
        rx1_done = 1'b1; tick(); rx1_done = 1'b0;
        chk("R4 phy_start after rx1", phy_start, 1);
        chk("R4 no bo_load", bo_load, 0);
        tick();
        phy_tx_done = 1'b1; tick(); phy_tx_done = 1'b0;
        chk("R10 done after pre-wait", done, 1);
        tick();

        // R5 post-transmit pre-wait alone, medium busy
        set_cfg(1, 1, 9, 0, 1, 0);
        medium_idle_difs = 1'b0;
        expect_run(1, 1, 0);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk("R5 waiting tx1", phy_start, 0);
        chk("R5 no bo_load", bo_load, 0);
        tick();
        tx1_done = 1'b1; tick(); tx1_done = 1'b0;
        chk("R5 phy_start after tx1", phy_start, 1);
        tick();
        phy_tx_done = 1'b1; tick(); phy_tx_done = 1'b0;
        tick();

        // R7 fresh backoff, R3 ignored edge, R11 response
        set_cfg(4, 0, 15, 0, 0, 1);
        q_bo.push_back(15);
        expect_run(4, 0, 1);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk("R7 bo_load", bo_load, 1);
        chk("R7 bo_slots", bo_slots, 15);
        tick();
        chk("R7 bo_load single", bo_load, 0);
        chk("R7 no phy_start before bo_done", phy_start, 0);
        medium_idle_difs = 1'b1; sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk("R3 no phy_start", phy_start, 0);
        chk("R3 no bo_load", bo_load, 0);
        chk("R3 still busy", busy, 1);
        bo_done = 1'b1; tick(); bo_done = 1'b0;
        chk("R7 phy_start after bo_done", phy_start, 1);
        tick();
        phy_tx_done = 1'b1; tick(); phy_tx_done = 1'b0;
        chk("R11 busy in window", busy, 1);
        chk("R11 no done yet", done, 0);
        tick();
        phy_rx_start = 1'b1; tick(); phy_rx_start = 1'b0;
        chk("R11 done", done, 1);
        chk("R11 result", result, 1);
        tick();

        // R8 deferral, R12 timeout
        set_cfg(3, 3, 2, 0, 0, 1);
        bo_active = 1'b1;
        expect_run(3, 3, 2);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk("R8 no bo_load", bo_load, 0);
        chk("R8 no phy_start", phy_start, 0);
        tick();
        chk("R8 waiting", phy_start, 0);
        bo_done = 1'b1; bo_active = 1'b0; tick(); bo_done = 1'b0;
        chk("R8 phy_start after bo_done", phy_start, 1);
        tick();
        phy_tx_done = 1'b1; tick(); phy_tx_done = 1'b0;
        tick();
        tx2_done = 1'b1; tick(); tx2_done = 1'b0;
        chk("R12 done", done, 1);
        chk("R12 timeout result", result, 2);
        tick();
        chk("R13 result holds", result, 2);

        // R12 simultaneous reception and expiry
        set_cfg(2, 1, 0, 0, 0, 1);
        expect_run(2, 1, 1);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        tick();
        phy_tx_done = 1'b1; tick(); phy_tx_done = 1'b0;
        phy_rx_start = 1'b1; tx2_done = 1'b1; tick();
        phy_rx_start = 1'b0; tx2_done = 1'b0;
        chk("R12 tie result", result, 1);
        tick();

        // R1 reset in the middle of a run
        set_cfg(5, 1, 0, 1, 0, 0);
        sw_go = 1'b1; tick(); sw_go = 1'b0;
        chk("R1 busy before reset", busy, 1);
        rst_n = 1'b0; #1;
        chk("R1 busy cleared", busy, 0);
        chk("R1 done cleared", done, 0);
        chk("R1 phy_start cleared", phy_start, 0);
        tick(); rst_n = 1'b1; tick();
        chk("R1 idle after release", busy, 0);
        rx1_done = 1'b1; tick(); rx1_done = 1'b0;
        chk("R1 no leftover start", phy_start, 0);
        tick();

        chk("R9 phy queue drained", q_phy.size(), 0);
        chk("R7 bo queue drained", q_bo.size(), 0);
        chk("R13 result queue drained", q_res.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule